// File: doc/BRIEF.md
# Cartridge Bank Mapping Register File

This block holds the bank numbers that a cartridge memory mapper uses to place large program and character ROMs behind the small address windows of a console. The processor writes bank numbers over its own bus: address, data and a write strobe. The block then turns every program address into an 8 KiB program ROM bank number and every pattern-table address into a 1 KiB character ROM bank number. These numbers form the high address bits of the two ROMs, and the low bits come straight from the bus that is reading.

The program space from 0x8000 to 0xFFFF is split into four 8 KiB windows. The two lower windows can be switched by writes. The two upper windows always show the last two banks of the ROM, so start-up and interrupt code is always present. The pattern space is split into eight 1 KiB slots, and each slot has its own 8-bit bank register. Each of these registers is written four bits at a time, through a pair of ports: one for the low nibble and one for the high nibble.

Top module: `bank_map_regs`

## Requirements
- R1: A write strobe with cpu_addr[15:12] = 4'h8 stores all eight bits of cpu_data as the bank for window 0 (cpu_addr[14:13] = 2'b00).
- R2: A write strobe with cpu_addr[15:12] = 4'hA stores all eight bits of cpu_data as the bank for window 1 (cpu_addr[14:13] = 2'b01).
- R3: When cpu_addr[14:13] = 2'b10, prg_bank is PRG_BANKS-2. When cpu_addr[14:13] = 2'b11, prg_bank is PRG_BANKS-1. Writes never change these two values.
- R4: After reset, window 0 holds bank 0, window 1 holds bank 1, and character slot n holds bank n for n = 0..7.
- R5: A character register is selected by cpu_addr & 16'hF00C. High nibble h of B, C, D or E together with address bit 3 selects register 2*(h-4'hB) + cpu_addr[3]. Address bits 11:4 and 1:0 play no part in the selection.
- R6: A character write with cpu_addr[2] = 0 (the low port) copies cpu_data[3:0] into bits 3:0 of the register and leaves bits 7:4 unchanged. cpu_data[7:4] is ignored.
- R7: A character write with cpu_addr[2] = 1 (the high port) copies cpu_data[3:0] into bits 7:4 of the register and leaves bits 3:0 unchanged.
- R8: chr_bank shows the register that ppu_addr[12:10] selects.
- R9: For windows 0 and 1, prg_bank is the stored byte modulo PRG_BANKS.
- R10: A write changes the outputs only after the rising clock edge on which cpu_wr is high. When cpu_wr is low, nothing changes. Writes with cpu_addr[15:12] equal to 0x0–0x7, 0x9 or 0xF change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address, used for write decode and for program window lookup |
| cpu_data | input | 8 | Processor write data |
| cpu_wr | input | 1 | Write strobe, sampled on the rising edge |
| ppu_addr | input | 13 | Pattern-table address |
| prg_bank | output | PRG_W | Program ROM 8 KiB bank number for cpu_addr |
| chr_bank | output | 8 | Character ROM 1 KiB bank number for ppu_addr |

## Verification
The bench targets the half-register updates. A design that merged the nibbles the wrong way round, or that copied cpu_data[7:4] into the low port, would show mismatched character banks right after a single write to one port. The bench also writes through aliased addresses, with stray bits in 11:4 and 1:0, and to the unused high-nibble rows 0x9 and 0xF. A decoder that is too loose or too strict would then hit the wrong slot, or miss the right one. The bench stores bytes above the bank count to expose a missing modulo, and watches the fixed windows across every write. A fixed window that could be overwritten, or that was computed from the wrong end of the ROM, would then show up.

// File: rtl/bank_map_regs.sv
module bank_map_regs #(
  parameter int PRG_BANKS = 32,
  localparam int PRG_W = (PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      cpu_addr,
  input  logic [7:0]       cpu_data,
  input  logic             cpu_wr,
  input  logic [12:0]      ppu_addr,
  output logic [PRG_W-1:0] prg_bank,
  output logic [7:0]       chr_bank
);
  localparam logic [PRG_W-1:0] BANK_LAST = PRG_W'(PRG_BANKS - 1);
  localparam logic [PRG_W-1:0] BANK_PREV = PRG_W'(PRG_BANKS - 2);

  logic [7:0]      win0_q, win1_q;
  logic [7:0][7:0] chr_q;

  wire [3:0] row     = cpu_addr[15:12];
  wire [3:0] row_off = row - 4'hB;
  wire       chr_hit = cpu_wr && (row >= 4'hB) && (row <= 4'hE);
  wire [2:0] chr_idx = {row_off[1:0], cpu_addr[3]};
  wire       hi_port = cpu_addr[2];

  function automatic logic [PRG_W-1:0] wrap(input logic [7:0] b);
    return PRG_W'(32'(b) % PRG_BANKS);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win0_q <= 8'd0;
      win1_q <= 8'd1;
      for (int k = 0; k < 8; k++) chr_q[k] <= 8'(k);
    end else begin
      if (cpu_wr && row == 4'h8) win0_q <= cpu_data;
      if (cpu_wr && row == 4'hA) win1_q <= cpu_data;
      if (chr_hit) begin
        if (hi_port) chr_q[chr_idx][7:4] <= cpu_data[3:0];
        else         chr_q[chr_idx][3:0] <= cpu_data[3:0];
      end
    end
  end

  always_comb begin
    unique case (cpu_addr[14:13])
      2'b00:   prg_bank = wrap(win0_q);
      2'b01:   prg_bank = wrap(win1_q);
      2'b10:   prg_bank = BANK_PREV;
      default: prg_bank = BANK_LAST;
    endcase
  end

  assign chr_bank = chr_q[ppu_addr[12:10]];
endmodule

// File: rtl/bank_map_regs_chk.sv
module bank_map_regs_chk #(
  parameter int PRG_BANKS = 32,
  parameter int PRG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [15:0]      cpu_addr,
  input logic [7:0]       cpu_data,
  input logic             cpu_wr,
  input logic [PRG_W-1:0] prg_bank,
  input logic [7:0]       win0_q,
  input logic [7:0]       win1_q,
  input logic [7:0][7:0]  chr_q
);
  wire [15:0] masked = cpu_addr & 16'hF00C;

  AST_WIN0_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:12] == 4'h8) |=> win0_q == $past(cpu_data)); // R1
  AST_WIN1_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:12] == 4'hA) |=> win1_q == $past(cpu_data)); // R2
  AST_FIXED_PREV: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[14:13] == 2'b10 |-> prg_bank == PRG_W'(PRG_BANKS - 2)); // R3
  AST_FIXED_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[14:13] == 2'b11 |-> prg_bank == PRG_W'(PRG_BANKS - 1)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |=> $stable(win0_q) && $stable(win1_q) && $stable(chr_q)); // R10

  for (genvar k = 0; k < 8; k++) begin : g_slot
    localparam logic [15:0] LO_ADR = 16'hB000 + 16'((k / 2) * 16'h1000) + 16'((k % 2) * 8);
    localparam logic [15:0] HI_ADR = LO_ADR + 16'h0004;
    AST_LO_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && masked == LO_ADR) |=>
        chr_q[k][3:0] == $past(cpu_data[3:0]) && chr_q[k][7:4] == $past(chr_q[k][7:4])); // R6
    AST_HI_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && masked == HI_ADR) |=>
        chr_q[k][7:4] == $past(cpu_data[3:0]) && chr_q[k][3:0] == $past(chr_q[k][3:0])); // R7
  end
endmodule

bind bank_map_regs bank_map_regs_chk #(.PRG_BANKS(PRG_BANKS), .PRG_W(PRG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr),
  .prg_bank(prg_bank), .win0_q(win0_q), .win1_q(win1_q), .chr_q(chr_q)
);

// File: tb/bank_map_regs_bench.sv
`timescale 1ns/1ps
module bank_map_regs_bench;
  localparam int NB = 32;
  localparam int PW = $clog2(NB);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   cpu_addr = 16'h8000;
  logic [7:0]    cpu_data = 8'h00;
  logic          cpu_wr = 1'b0;
  logic [12:0]   ppu_addr = 13'h0;
  logic [PW-1:0] prg_bank;
  logic [7:0]    chr_bank;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  int m_w0, m_w1;
  int m_chr[8];

  always #2.5 clk = ~clk;

  bank_map_regs #(.PRG_BANKS(NB)) u_bank_map_regs (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_bank(prg_bank), .chr_bank(chr_bank));

  function automatic int exp_prg(logic [15:0] a);
    case (a[14:13])
      2'b00:   return m_w0 % NB;
      2'b01:   return m_w1 % NB;
      2'b10:   return NB - 2;
      default: return NB - 1;
    endcase
  endfunction

  task automatic model_reset();
    m_w0 = 0; m_w1 = 1;
    for (int k = 0; k < 8; k++) m_chr[k] = k;
  endtask

  task automatic model_write(logic [15:0] a, logic [7:0] d);
    int h, idx;
    h = a[15:12];
    if (h == 8) m_w0 = d;
    else if (h == 10) m_w1 = d;
    else if (h >= 11 && h <= 14) begin
      idx = (h - 11) * 2 + a[3];
      if (a[2]) m_chr[idx] = (m_chr[idx] & 8'h0F) | ((d & 8'h0F) << 4);
      else      m_chr[idx] = (m_chr[idx] & 8'hF0) | (d & 8'h0F);
    end
  endtask

  task automatic cyc(logic [15:0] a, logic [7:0] d, logic w, logic [12:0] p, string tag);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = w; ppu_addr = p;
    #1;
    checks++;
    if (int'(prg_bank) != exp_prg(a)) begin
      errors++;
      $display("FAIL %s prg_bank addr=%h actual=%0d expected=%0d", tag, a, prg_bank, exp_prg(a));
    end
    checks++;
    if (int'(chr_bank) != m_chr[p[12:10]]) begin
      errors++;
      $display("FAIL %s chr_bank slot=%0d actual=%0d expected=%0d", tag, p[12:10], chr_bank, m_chr[p[12:10]]);
    end
    @(posedge clk);
    if (w) model_write(a, d);
  endtask

  task automatic sweep(string tag);
    for (int k = 0; k < 8; k++) cyc(16'h8000 + 16'(k * 16'h2000 % 16'h8000), 8'h00, 1'b0, 13'(k << 10) | 13'h3FF, tag);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    sweep("R4");
    cyc(16'h8123, 8'hA5, 1'b1, 13'h0000, "R1");
    cyc(16'h8000, 8'h00, 1'b0, 13'h0000, "R1 R9");
    cyc(16'hA7FF, 8'h13, 1'b1, 13'h0400, "R2");
    cyc(16'hA000, 8'h00, 1'b0, 13'h0400, "R2");
    cyc(16'h8000, 8'h00, 1'b0, 13'h0400, "R9");
    cyc(16'hC000, 8'h00, 1'b0, 13'h0800, "R3");
    cyc(16'hE000, 8'h00, 1'b0, 13'h0C00, "R3");
    cyc(16'hB000, 8'hF9, 1'b1, 13'h0000, "R6");
    cyc(16'hB000, 8'h00, 1'b0, 13'h0000, "R6");
    cyc(16'hB004, 8'hE6, 1'b1, 13'h0000, "R7");
    cyc(16'hB000, 8'h00, 1'b0, 13'h0000, "R7");
    cyc(16'hD00B, 8'h0C, 1'b1, 13'h1400, "R5");
    cyc(16'hDFFF, 8'h07, 1'b1, 13'h1400, "R5");
    cyc(16'hE5F3, 8'h00, 1'b0, 13'h1C00, "R5");
    cyc(16'h9000, 8'h55, 1'b1, 13'h0000, "R10");
    cyc(16'hF00C, 8'h55, 1'b1, 13'h1C00, "R10");
    cyc(16'h4000, 8'h55, 1'b1, 13'h0800, "R10");
    cyc(16'h8000, 8'h77, 1'b0, 13'h0000, "R10");
    cyc(16'hC008, 8'h3F, 1'b0, 13'h0C00, "R10");
    cyc(16'hC008, 8'h00, 1'b0, 13'h0C00, "R10");
    sweep("R8");
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      a = 16'($urandom);
      if (($urandom & 3) != 0) a[15:12] = 4'(8 + $urandom_range(0, 7));
      cyc(a, 8'($urandom), 1'($urandom), 13'($urandom), "R5 R8 R9");
    end
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    model_reset();
    #1 rst_n = 1'b1;
    sweep("R4");
    done = 1;
    finish_run();
  end

  initial begin
    while (!done && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
      finish_run();
    end
  end
endmodule